// File: doc/BRIEF.md
# Serial expansion FIFO bridge

The bridge sits between a host register port and a 16550-style UART core and adds a 16-entry byte FIFO in each direction. The host writes bytes for transmission and reads received bytes through one shared data offset. The bridge hands queued transmit bytes to the UART transmitter over a valid/ready handshake. It takes bytes from the UART receiver into the receive FIFO whenever there is room.

A mode register turns the FIFOs on. It can also swap the two 8-byte halves of each 16-byte group of storage. Two bits in a modem-control register stop each transfer path on its own. A status byte reports full, half-full and empty for both FIFOs. One of its flags is active low. A host write to the status offset empties both FIFOs at once. Host reads return data in the same cycle. Side effects take place at the next clock edge.

Top module: `serfifo_top`

## Requirements
- R1: After reset the mode and modem-control registers read 0x00, and the status byte at offset 0x2 reads 0x29.
- R2: The mode register at offset 0x0 keeps bit 2 (FIFO enable) and bit 0 (half swap). Bit 1 and bits 7..3 always read 0 and ignore writes.
- R3: While mode bit 2 is 0, host writes to the data offset 0x8 are dropped, host reads there return 0x00, txValid is 0 and rxTake is 0.
- R4: With the FIFOs enabled, bytes written at offset 0x8 appear on txData with txValid, in write order. One byte leaves per cycle in which txValid and txReady are both 1.
- R5: With the FIFOs enabled, a byte on rxData is stored when rxTake is 1. Host reads at 0x8 return stored bytes in arrival order. A read of an empty receive FIFO returns 0x00 and changes nothing.
- R6: The status byte has bit 5 = receive not full, bit 4 = receive holds 8 or more, bit 3 = receive empty, bit 2 = transmit full, bit 1 = transmit holds 8 or more, and bit 0 = transmit empty. Bits 7 and 6 read 0.
- R7: A host write to a full transmit FIFO is dropped, even if a byte leaves in the same cycle. rxTake is 0 while the receive FIFO is full.
- R8: In the modem-control register at offset 0xC, bit 3 = 1 holds rxTake at 0 and bit 2 = 1 holds txValid at 0. Only bits 3 and 2 are stored and read back.
- R9: Any host write to offset 0x2 empties both FIFOs on the next edge. Other register contents are kept.
- R10: While mode bit 0 is 1, each FIFO slot index has bit 3 inverted before it addresses storage. Sixteen bytes written with the swap off and drained with it on come out as bytes 8..15, then 0..7.
- R11: A push and a pop on the same FIFO in one cycle both take effect, and the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 4 | Register offset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid in the cycle of hostRd |
| txData | output | 8 | Byte offered to the UART transmitter |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | UART transmitter accepts txData |
| rxData | input | 8 | Byte from the UART receiver |
| rxValid | input | 1 | rxData is valid |
| rxTake | output | 1 | Bridge stores rxData this cycle |

## Verification
The assertions assume that hostWr and hostRd are never high in the same cycle. They also assume the UART model drops rxValid or changes rxData only after a cycle in which rxTake was seen, or treats each cycle as a new offer. The random stimulus issues at most one host operation per cycle and treats every cycle's rxData as a new offer. The bench's reference queues follow exactly that reading. Modem-control writes come rarely and at random, so both blocked and unblocked stretches occur. The half swap is exercised only by a directed case, because the random model keeps it off.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
  localparam int DATA_W = 8;
  localparam int FIFO_DEPTH = 16;
  localparam logic [3:0] ADDR_MODE = 4'h0;
  localparam logic [3:0] ADDR_STAT = 4'h2;
  localparam logic [3:0] ADDR_DATA = 4'h8;
  localparam logic [3:0] ADDR_MCTL = 4'hC;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
    logic swap;
  } ctrlStrobes_t;

  typedef struct packed {
    logic txEmpty;
    logic txHalf;
    logic txFull;
    logic rxEmpty;
    logic rxHalf;
    logic rxFull;
  } fifoFlags_t;
endpackage

// File: rtl/serfifo_fifo.sv
module serfifo_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic             swap,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             half,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] SWAP_MASK = AW'(DEPTH / 2);
  localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic [AW-1:0] wrAddr, rdAddr;

  assign wrAddr = swap ? (wrPtr ^ SWAP_MASK) : wrPtr;
  assign rdAddr = swap ? (rdPtr ^ SWAP_MASK) : rdPtr;
  assign head  = mem[rdAddr];
  assign empty = (count == '0);
  assign full  = (count == FULL_LVL);
  assign half  = (count >= HALF_LVL);

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrAddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
  p_push_pop_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !flush) |=> $stable(count));
endmodule

// File: rtl/serfifo_dp.sv
module serfifo_dp
  import serfifo_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] hostWdata,
  input  logic [WIDTH-1:0] rxData,
  output logic [WIDTH-1:0] txHead,
  output logic [WIDTH-1:0] rxHead,
  output fifoFlags_t       flags
);
  serfifo_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pop(strb.txPop), .flush(strb.flush), .swap(strb.swap),
    .wdata(hostWdata), .head(txHead),
    .empty(flags.txEmpty), .half(flags.txHalf), .full(flags.txFull)
  );

  serfifo_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.rxPush), .pop(strb.rxPop), .flush(strb.flush), .swap(strb.swap),
    .wdata(rxData), .head(rxHead),
    .empty(flags.rxEmpty), .half(flags.rxHalf), .full(flags.rxFull)
  );
endmodule

// File: rtl/serfifo_ctrl.sv
module serfifo_ctrl
  import serfifo_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       hostAddr,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [WIDTH-1:0] hostWdata,
  output logic [WIDTH-1:0] hostRdata,
  input  logic             rxValid,
  input  logic             txReady,
  output logic             txValid,
  output logic             rxTake,
  input  fifoFlags_t       flags,
  input  logic [WIDTH-1:0] rxHead,
  output ctrlStrobes_t     strb
);
  logic fifoEn, swapEn, rxBlock, txBlock;
  logic dataSel;
  logic [WIDTH-1:0] statusByte, modeByte, mctlByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      swapEn  <= 1'b0;
      rxBlock <= 1'b0;
      txBlock <= 1'b0;
    end else if (hostWr) begin
      if (hostAddr == ADDR_MODE) begin
        fifoEn <= hostWdata[2];
        swapEn <= hostWdata[0];
      end
      if (hostAddr == ADDR_MCTL) begin
        rxBlock <= hostWdata[3];
        txBlock <= hostWdata[2];
      end
    end
  end

  assign dataSel = fifoEn && (hostAddr == ADDR_DATA);
  assign txValid = fifoEn && !txBlock && !flags.txEmpty;
  assign rxTake  = fifoEn && !rxBlock && !flags.rxFull && rxValid;

  always_comb begin
    strb.txPush = hostWr && dataSel && !flags.txFull;
    strb.txPop  = txValid && txReady;
    strb.rxPush = rxTake;
    strb.rxPop  = hostRd && dataSel && !flags.rxEmpty;
    strb.flush  = hostWr && (hostAddr == ADDR_STAT);
    strb.swap   = swapEn;
  end

  always_comb begin
    statusByte = '0;
    statusByte[5] = !flags.rxFull;
    statusByte[4] = flags.rxHalf;
    statusByte[3] = flags.rxEmpty;
    statusByte[2] = flags.txFull;
    statusByte[1] = flags.txHalf;
    statusByte[0] = flags.txEmpty;
    modeByte = '0;
    modeByte[2] = fifoEn;
    modeByte[0] = swapEn;
    mctlByte = '0;
    mctlByte[3] = rxBlock;
    mctlByte[2] = txBlock;
  end

  always_comb begin
    hostRdata = '0;
    if (hostRd) begin
      unique case (hostAddr)
        ADDR_MODE: hostRdata = modeByte;
        ADDR_STAT: hostRdata = statusByte;
        ADDR_MCTL: hostRdata = mctlByte;
        ADDR_DATA: hostRdata = (dataSel && !flags.rxEmpty) ? rxHead : '0;
        default:   hostRdata = '0;
      endcase
    end
  end

  p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    txBlock |-> !strb.txPop);
  p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxBlock |-> !strb.rxPush);
  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> !(strb.txPush || strb.txPop || strb.rxPush || strb.rxPop));
  p_one_host_op: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostRd));
endmodule

// File: rtl/serfifo_top.sv
module serfifo_top
  import serfifo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  hostAddr,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  output logic        rxTake
);
  ctrlStrobes_t strb;
  fifoFlags_t flags;
  logic [DATA_W-1:0] rxHead;

  serfifo_ctrl #(.WIDTH(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .rxValid(rxValid), .txReady(txReady),
    .txValid(txValid), .rxTake(rxTake),
    .flags(flags), .rxHead(rxHead), .strb(strb)
  );

  serfifo_dp #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWdata(hostWdata), .rxData(rxData),
    .txHead(txData), .rxHead(rxHead), .flags(flags)
  );
endmodule

// File: tb/sim_serfifo_top.sv
module sim_serfifo_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata, txData, rxData = '0;
  logic txValid, rxTake;
  logic txReady = 1'b0, rxValid = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serfifo_top u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int statusOf(input int rxN, input int txN);
    return ((rxN < 16) << 5) | ((rxN >= 8) << 4) | ((rxN == 0) << 3) |
           ((txN == 16) << 2) | ((txN >= 8) << 1) | (txN == 0);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    hostWr = 0; hostRd = 0; rxValid = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1;
    tick();
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string req);
    hostAddr = a; hostRd = 1; #1;
    check(req, hostRdata, exp);
    tick();
  endtask

  task automatic rxPush(input logic [7:0] d, input int expTake, input string req);
    rxData = d; rxValid = 1; #1;
    check(req, rxTake, expTake);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int txQ[$];
    int rxQ[$];
    void'($urandom(32'h1234abcd));
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'h2, 8'h29, "R1 status");
    rd(4'h0, 8'h00, "R1 mode");
    rd(4'hC, 8'h00, "R1 mctl");
    // R3 disabled FIFOs
    wr(4'h8, 8'h55);
    rd(4'h2, 8'h29, "R3 write dropped");
    rxPush(8'h11, 0, "R3 rxTake off");
    rd(4'h8, 8'h00, "R3 read zero");
    #1 check("R3 txValid off", txValid, 0);
    // R2 reserved mode bits
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h05, "R2 mode readback");
    wr(4'h0, 8'h04);
    // R8 mctl readback and tx blocking; R7 overfill
    wr(4'hC, 8'hFF);
    rd(4'hC, 8'h0C, "R8 mctl readback");
    rxPush(8'h22, 0, "R8 rx blocked");
    wr(4'hC, 8'h04);
    for (int i = 0; i < 17; i++) wr(4'h8, 8'h40 + i[7:0]);
    #1 check("R8 tx blocked", txValid, 0);
    rd(4'h2, 8'h2E, "R6 R7 tx full status");
    wr(4'hC, 8'h00);
    // R4 drain in order; 17th byte absent
    txReady = 1;
    for (int i = 0; i < 16; i++) begin
      #1 check("R4 txValid", txValid, 1);
      check("R4 txData", txData, 8'h40 + i);
      tick();
    end
    #1 check("R7 17th dropped", txValid, 0);
    txReady = 0;
    // R5 empty read leaves pointers alone
    rd(4'h8, 8'h00, "R5 empty read");
    rxPush(8'h3C, 1, "R5 take");
    rd(4'h8, 8'h3C, "R5 data");
    // R7 rx full
    for (int i = 0; i < 16; i++) rxPush(8'h80 + i[7:0], 1, "R5 fill");
    rxPush(8'hEE, 0, "R7 rx full refuse");
    rd(4'h2, 8'h11, "R6 rx full status");
    rd(4'h8, 8'h80, "R5 first out");
    // R9 flush
    wr(4'h2, 8'h00);
    rd(4'h2, 8'h29, "R9 flushed");
    rd(4'h0, 8'h04, "R9 mode kept");
    // R10 swap
    wr(4'hC, 8'h04);
    for (int i = 0; i < 16; i++) wr(4'h8, 8'hA0 + i[7:0]);
    wr(4'h0, 8'h05);
    wr(4'hC, 8'h00);
    txReady = 1;
    for (int i = 0; i < 16; i++) begin
      #1 check("R10 swapped order", txData, 8'hA0 + ((i + 8) % 16));
      tick();
    end
    txReady = 0;
    wr(4'h0, 8'h04);
    wr(4'h2, 8'h00);
    // R11 same-cycle push and pop on rx
    rxPush(8'h61, 1, "R11 setup");
    hostAddr = 4'h8; hostRd = 1; rxData = 8'h62; rxValid = 1; #1;
    check("R11 read", hostRdata, 8'h61);
    check("R11 take", rxTake, 1);
    tick();
    rd(4'h2, 8'h29 & ~8'h08, "R11 occupancy one");
    rd(4'h8, 8'h62, "R11 data");

    // Random phase against reference queues (R4 R5 R6 R7 R8 R11)
    begin
      bit rb = 0, tb = 0;
      for (int c = 0; c < 4000; c++) begin
        int op;
        bit expTv, expTake, doWr, doRd;
        op = $urandom % 16;
        rxValid = $urandom % 2; rxData = $urandom; txReady = $urandom % 2;
        doWr = (op <= 4); doRd = (op >= 5 && op <= 9);
        hostWdata = $urandom;
        if (doWr) begin hostAddr = 4'h8; hostWr = 1; end
        if (doRd) begin hostAddr = 4'h8; hostRd = 1; end
        if (op == 10 || op == 11) begin hostAddr = 4'h2; hostRd = 1; end
        if (op == 12 && ($urandom % 4 == 0)) begin
          hostAddr = 4'hC; hostWr = 1;
          hostWdata = {4'h0, 1'($urandom % 2), 1'($urandom % 2), 2'b00};
        end
        #1;
        expTv = (txQ.size() > 0) && !tb;
        expTake = rxValid && !rb && (rxQ.size() < 16);
        check("R8 R4 txValid", txValid, expTv);
        if (expTv) check("R4 txData", txData, txQ[0]);
        check("R7 R8 rxTake", rxTake, expTake);
        if (doRd) check("R5 read", hostRdata, rxQ.size() ? rxQ[0] : 0);
        if (op == 10 || op == 11) check("R6 status", hostRdata, statusOf(rxQ.size(), txQ.size()));
        if (doWr && txQ.size() < 16) txQ.push_back(hostWdata);
        if (expTv && txReady) void'(txQ.pop_front());
        if (doRd && rxQ.size()) void'(rxQ.pop_front());
        if (expTake) rxQ.push_back(rxData);
        if (hostWr && hostAddr == 4'hC) begin rb = hostWdata[3]; tb = hostWdata[2]; end
        tick();
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule